// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Masking

This block sits between a set of external interrupt request lines and a processor core model. It latches each request on a rising edge, filters the latched requests through per-line enables, a priority threshold and a global mask, and picks one winner by priority. When the winner outranks the handler the core is running, the block offers its vector number on a level-held take strobe. The core accepts with an acknowledge pulse and later retires the handler with a completion pulse.

A non-maskable request sits above every configurable line. Its rank is fixed and no register can change it. The block keeps the priority level of the running handler. It also keeps a small stack of the levels that handler preempted, so nested handlers unwind in order. Software sets priorities, enables, pending bits, the threshold and the global mask through a single-cycle register write port. A combinational read port returns those values. A wake output tells a sleeping core that a request it should look at has arrived.

Register offsets (word addresses):
- 0: control. Bit 0 is the global mask.
- 1: threshold. Bits 7:4 hold the threshold.
- 2: enable, one bit per line.
- 3: pending-set. Writing 1 sets a bit. Reads return the pending bits.
- 4: pending-clear. Writing 1 clears a bit. Reads return the pending bits.
- 8 onward: priority words. Each word carries four 8-bit fields, with line n in word 8+n/4 at byte n%4.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After synchronous reset, take_valid, take_vector and wake are 0, and every register reads as 0. The running level is the thread level, which ranks below every configurable priority.
- R2: Only bits 7:4 of each 8-bit priority field and of the threshold register are stored. Bits 3:0 ignore writes and read as 0.
- R3: A line's pending bit is set on a rising edge of its request line. Holding the line high does not set it again. The bit is cleared by an acknowledge of that line, or by writing 1 to it at offset 4. Writing 1 at offset 3 sets it. If a set and a clear fall in the same cycle, the set wins.
- R4: Only lines that are pending and enabled compete. The lowest priority value wins, and among equal values the lowest line number wins. The vector offered is 16 plus the line number. take_vector is 0 whenever take_valid is 0.
- R5: A nonzero threshold keeps every line whose priority value is greater than or equal to the threshold from being taken. A threshold of 0 masks nothing.
- R6: Control bit 0 set to 1 blocks every configurable line from being taken. A pending non-maskable request is still offered, with vector 2.
- R7: A configurable request is offered only if its priority value is strictly lower than that of the running handler. An equal or lower-ranked request stays pending until completions bring the running level below it.
- R8: The non-maskable request is latched on a rising edge and outranks every configurable level. It cannot be preempted by any configurable line, and it is not offered again while its own handler runs.
- R9: A completion restores the running level to the level the finished handler preempted, up to 16 stacked levels. When nothing is stacked, it restores the thread level. A completion at thread level has no effect.
- R10: While core_sleep is 1, wake is 1 if the non-maskable request is pending, or if some pending enabled line is not held off by the threshold. This holds even when the global mask blocks the line. wake is 0 while core_sleep is 0.
- R11: An acknowledge and a completion in the same cycle first retire the running handler, then start the offered one. The level stacked under the new handler is the level the retired handler had preempted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address for both write and read |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational from reg_addr) |
| irq_req | input | NUM_LINES | External request lines, latched on rising edge |
| nmi_req | input | 1 | Non-maskable request, latched on rising edge |
| core_ack | input | 1 | Core accepts the offered vector this cycle |
| core_done | input | 1 | Core completes the running handler this cycle |
| core_sleep | input | 1 | Core is sleeping |
| take_valid | output | 1 | A vector is offered to the core |
| take_vector | output | 8 | Offered vector number |
| wake | output | 1 | Wake request to a sleeping core |

## Verification
The case that needs the most care is an acknowledge and a completion landing on the same edge. A wrong order there leaves a stale level on the preemption stack, and it shows up only several completions later. The bench builds a two-deep nest and fires both pulses together. It then checks that a new mid-priority request is held off by the new handler. After one more completion, it checks that the same request is offered, because the level underneath must be the one the retired handler preempted. A second overlap, a request edge landing in the same cycle as a pending-clear write, is judged by reading the pending bit back.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    // Implemented priority bits and the 8-bit field that holds them
    localparam int PRIO_W  = 4;
    localparam int FIELD_W = 8;

    // Internal rank: smaller is more urgent.
    // 0 reset (never taken here), 1 non-maskable, 2 hard fault,
    // 3.. configurable, last one the thread level.
    localparam int LVL_W = PRIO_W + 2;
    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_NMI    = lvl_t'(1);
    localparam lvl_t LVL_FAULT  = lvl_t'(2);
    localparam lvl_t LVL_THREAD = lvl_t'((1 << PRIO_W) + 3);

    localparam int VEC_W = 8;
    localparam logic [VEC_W-1:0] VEC_NMI      = VEC_W'(2);
    localparam logic [VEC_W-1:0] VEC_EXT_BASE = VEC_W'(16);

    // Register word offsets
    localparam int REG_CTRL      = 0;
    localparam int REG_THRESH    = 1;
    localparam int REG_ENABLE    = 2;
    localparam int REG_PEND_SET  = 3;
    localparam int REG_PEND_CLR  = 4;
    localparam int REG_PRIO_BASE = 8;

    typedef struct packed {
        logic              mask_all;
        logic [PRIO_W-1:0] thresh;
    } ctrl_t;

    typedef struct packed {
        logic             valid;
        logic             is_nmi;
        lvl_t             lvl;
        logic [VEC_W-1:0] vec;
    } take_t;

    function automatic lvl_t cfg_level(input logic [PRIO_W-1:0] p);
        return lvl_t'(p) + LVL_FAULT + lvl_t'(1);
    endfunction

    function automatic logic thr_blocks(input logic [PRIO_W-1:0] p,
                                        input logic [PRIO_W-1:0] t);
        return (t != '0) && (p >= t);
    endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] sw_clr,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] pend
);

    logic [N-1:0] req_q;
    logic [N-1:0] rise;
    logic [N-1:0] pend_d;

    assign rise = req & ~req_q;

    // Clears apply first, then any set source wins
    assign pend_d = (pend & ~(sw_clr | ack_clr)) | rise | sw_set;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            pend  <= '0;
        end else begin
            req_q <= req;
            pend  <= pend_d;
        end
    end

    // An edge always leaves its line pending on the next cycle
    assert_edge_latches_R3: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((pend & $past(rise)) == $past(rise)));

endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
    import irq_arb_pkg::*;
#(
    parameter int N  = 32,
    localparam int IW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        elig,
    input  logic [N*PRIO_W-1:0] prio_flat,
    output logic                found,
    output logic [IW-1:0]       win_idx,
    output logic [PRIO_W-1:0]   win_prio
);

    // Linear scan: strict compare keeps the lowest index on ties
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] < win_prio)) begin
                found    = 1'b1;
                win_idx  = IW'(i);
                win_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

    assert_winner_eligible_R4: assert property (@(posedge clk) disable iff (rst)
        found |-> elig[win_idx]);

    assert_none_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (elig == '0) |-> !found);

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
    import irq_arb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int SP_W = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  lvl_t take_lvl,
    input  logic done,
    output lvl_t active_lvl
);

    lvl_t            stk [DEPTH];
    logic [SP_W-1:0] sp_q;
    lvl_t            base_lvl;
    logic [SP_W-1:0] base_sp;
    logic            push;
    lvl_t            nxt_lvl;
    logic [SP_W-1:0] nxt_sp;

    // Completion is applied before a same-cycle take
    always_comb begin
        base_lvl = active_lvl;
        base_sp  = sp_q;
        if (done && active_lvl != LVL_THREAD) begin
            if (sp_q == '0) begin
                base_lvl = LVL_THREAD;
            end else begin
                base_lvl = stk[IW'(sp_q - 1'b1)];
                base_sp  = sp_q - 1'b1;
            end
        end
        push    = take && (base_lvl != LVL_THREAD) && (base_sp < SP_W'(DEPTH));
        nxt_sp  = push ? base_sp + 1'b1 : base_sp;
        nxt_lvl = take ? take_lvl : base_lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_lvl <= LVL_THREAD;
            sp_q       <= '0;
        end else begin
            active_lvl <= nxt_lvl;
            sp_q       <= nxt_sp;
        end
    end

    always_ff @(posedge clk) begin
        if (push) stk[base_sp[IW-1:0]] <= base_lvl;
    end

    assert_thread_means_empty_R9: assert property (@(posedge clk) disable iff (rst)
        (active_lvl == LVL_THREAD) |-> (sp_q == '0));

    assert_stack_bounded_R9: assert property (@(posedge clk) disable iff (rst)
        sp_q <= SP_W'(DEPTH));

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_LINES   = 32,
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 32,
    parameter int STACK_DEPTH = 16,
    localparam int IDX_W = $clog2(NUM_LINES),
    localparam int FPW   = DATA_W / FIELD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NUM_LINES-1:0] irq_req,
    input  logic                 nmi_req,
    input  logic                 core_ack,
    input  logic                 core_done,
    input  logic                 core_sleep,
    output logic                 take_valid,
    output logic [VEC_W-1:0]     take_vector,
    output logic                 wake
);

    ctrl_t                     ctrl_q;
    logic [NUM_LINES-1:0]      en_q;
    logic [PRIO_W-1:0]         prio_q [NUM_LINES];
    logic [NUM_LINES*PRIO_W-1:0] prio_flat;
    logic [NUM_LINES-1:0]      thr_blk;
    logic [NUM_LINES-1:0]      pend;
    logic [NUM_LINES-1:0]      elig;
    logic [NUM_LINES-1:0]      sw_set, sw_clr, ack_clr;
    logic                      nmi_pend;
    logic                      nmi_ack;
    logic                      found;
    logic [IDX_W-1:0]          win_idx;
    logic [PRIO_W-1:0]         win_prio;
    lvl_t                      active_lvl;
    take_t                     take_s;
    logic                      core_take;

    // ---------------- register writes ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            en_q   <= '0;
            for (int i = 0; i < NUM_LINES; i++) prio_q[i] <= '0;
        end else if (reg_we) begin
            if (reg_addr == ADDR_W'(REG_CTRL))   ctrl_q.mask_all <= reg_wdata[0];
            if (reg_addr == ADDR_W'(REG_THRESH)) ctrl_q.thresh   <= reg_wdata[FIELD_W-1 -: PRIO_W];
            if (reg_addr == ADDR_W'(REG_ENABLE)) en_q            <= reg_wdata[NUM_LINES-1:0];
            for (int i = 0; i < NUM_LINES; i++) begin
                if (reg_addr == ADDR_W'(REG_PRIO_BASE + i / FPW))
                    prio_q[i] <= reg_wdata[(i % FPW)*FIELD_W + FIELD_W - 1 -: PRIO_W];
            end
        end
    end

    assign sw_set = (reg_we && reg_addr == ADDR_W'(REG_PEND_SET)) ? reg_wdata[NUM_LINES-1:0] : '0;
    assign sw_clr = (reg_we && reg_addr == ADDR_W'(REG_PEND_CLR)) ? reg_wdata[NUM_LINES-1:0] : '0;

    // ---------------- register reads ----------------
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(REG_CTRL))   reg_rdata[0] = ctrl_q.mask_all;
        if (reg_addr == ADDR_W'(REG_THRESH)) reg_rdata[FIELD_W-1 -: PRIO_W] = ctrl_q.thresh;
        if (reg_addr == ADDR_W'(REG_ENABLE)) reg_rdata[NUM_LINES-1:0] = en_q;
        if (reg_addr == ADDR_W'(REG_PEND_SET) || reg_addr == ADDR_W'(REG_PEND_CLR))
            reg_rdata[NUM_LINES-1:0] = pend;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (reg_addr == ADDR_W'(REG_PRIO_BASE + i / FPW))
                reg_rdata[(i % FPW)*FIELD_W + FIELD_W - 1 -: PRIO_W] = prio_q[i];
        end
    end

    // ---------------- per-line filtering ----------------
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
        assign thr_blk[g] = thr_blocks(prio_q[g], ctrl_q.thresh);
    end

    assign elig = pend & en_q & ~thr_blk;

    // ---------------- pending latches ----------------
    irq_pend_bank #(.N(NUM_LINES)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .req     (irq_req),
        .sw_set  (sw_set),
        .sw_clr  (sw_clr),
        .ack_clr (ack_clr),
        .pend    (pend)
    );

    irq_pend_bank #(.N(1)) u_nmi (
        .clk     (clk),
        .rst     (rst),
        .req     (nmi_req),
        .sw_set  (1'b0),
        .sw_clr  (1'b0),
        .ack_clr (nmi_ack),
        .pend    (nmi_pend)
    );

    // ---------------- winner and preemption ----------------
    irq_prio_select #(.N(NUM_LINES)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .elig      (elig),
        .prio_flat (prio_flat),
        .found     (found),
        .win_idx   (win_idx),
        .win_prio  (win_prio)
    );

    irq_level_stack #(.DEPTH(STACK_DEPTH)) u_stk (
        .clk        (clk),
        .rst        (rst),
        .take       (core_take),
        .take_lvl   (take_s.lvl),
        .done       (core_done),
        .active_lvl (active_lvl)
    );

    always_comb begin
        take_s = '0;
        if (nmi_pend && active_lvl > LVL_NMI) begin
            take_s.valid  = 1'b1;
            take_s.is_nmi = 1'b1;
            take_s.lvl    = LVL_NMI;
            take_s.vec    = VEC_NMI;
        end else if (!ctrl_q.mask_all && found && cfg_level(win_prio) < active_lvl) begin
            take_s.valid = 1'b1;
            take_s.lvl   = cfg_level(win_prio);
            take_s.vec   = VEC_EXT_BASE + VEC_W'(win_idx);
        end
    end

    assign core_take   = core_ack && take_s.valid;
    assign nmi_ack     = core_take && take_s.is_nmi;
    assign ack_clr     = (core_take && !take_s.is_nmi)
                         ? ({{(NUM_LINES-1){1'b0}}, 1'b1} << win_idx) : '0;
    assign take_valid  = take_s.valid;
    assign take_vector = take_s.vec;
    assign wake        = core_sleep && (nmi_pend || found);

    // ---------------- assertions ----------------
    assert_nmi_offered_R8: assert property (@(posedge clk) disable iff (rst)
        (nmi_pend && active_lvl != LVL_NMI) |-> (take_valid && take_vector == VEC_NMI));

    assert_mask_blocks_cfg_R6: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.mask_all |-> (!take_valid || take_vector == VEC_NMI));

    assert_take_preempts_R7: assert property (@(posedge clk) disable iff (rst)
        take_valid |-> (take_s.lvl < active_lvl));

    assert_take_wakes_R10: assert property (@(posedge clk) disable iff (rst)
        (core_sleep && take_valid) |-> wake);

    assert_vector_zero_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !take_valid |-> (take_vector == '0));

endmodule

// File: tb/tb_irq_prio_arbiter.sv
module tb_irq_prio_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NL-1:0] irq_req = '0;
    logic        nmi_req = 1'b0;
    logic        core_ack = 1'b0;
    logic        core_done = 1'b0;
    logic        core_sleep = 1'b0;
    logic        take_valid;
    logic [7:0]  take_vector;
    logic        wake;

    int n_chk = 0;
    int n_err = 0;

    logic [3:0]    m_prio [NL];
    logic [NL-1:0] m_en;
    logic [NL-1:0] m_pend;
    logic [3:0]    m_thr;
    logic          m_mask;
    logic          m_sleep;

    irq_prio_arbiter dut (
        .clk (clk), .rst (rst),
        .reg_we (reg_we), .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .irq_req (irq_req), .nmi_req (nmi_req),
        .core_ack (core_ack), .core_done (core_done), .core_sleep (core_sleep),
        .take_valid (take_valid), .take_vector (take_vector), .wake (wake)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        reg_addr = a; #1; v = reg_rdata;
        tick();
    endtask

    task automatic ack();
        core_ack = 1'b1; tick(); core_ack = 1'b0;
    endtask

    task automatic done();
        core_done = 1'b1; tick(); core_done = 1'b0;
    endtask

    task automatic wr_prio_word(input int w);
        logic [31:0] d;
        for (int l = 0; l < 4; l++) d[l*8 +: 8] = {m_prio[w*4+l], 4'($urandom)};
        wr(5'(8 + w), d);
    endtask

    task automatic set_prio(input int line, input logic [3:0] p);
        m_prio[line] = p;
        wr_prio_word(line / 4);
    endtask

    task automatic exp_take(input string tag, input logic [7:0] v);
        chk(tag, 32'(take_valid), 32'd1);
        chk(tag, 32'(take_vector), 32'(v));
    endtask

    task automatic exp_none(input string tag);
        chk(tag, 32'(take_valid), 32'd0);
        chk(tag, 32'(take_vector), 32'd0);
    endtask

    function automatic void model(output logic v, output logic [7:0] vec, output logic wk);
        logic f;
        int bi;
        logic [3:0] bp;
        f = 1'b0; bi = 0; bp = '0;
        for (int i = 0; i < NL; i++) begin
            if (m_pend[i] && m_en[i] && (m_thr == 0 || m_prio[i] < m_thr) && (!f || m_prio[i] < bp)) begin
                f = 1'b1; bi = i; bp = m_prio[i];
            end
        end
        v   = f && !m_mask;
        vec = v ? 8'(16 + bi) : 8'd0;
        wk  = m_sleep && f;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic ev, ew;
        logic [7:0] evec;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NL; i++) m_prio[i] = '0;
        m_en = '0;

        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        exp_none("R1 take after reset");
        chk("R1 wake after reset", 32'(wake), 0);
        for (int a = 0; a < 5; a++) begin
            rd(5'(a), v); chk("R1 register reset", v, 0);
        end
        rd(5'd8, v); chk("R1 priority reset", v, 0);

        // R2 low nibbles not stored
        wr(5'd8, 32'hFFFF_FFFF);
        rd(5'd8, v); chk("R2 priority low bits", v, 32'hF0F0_F0F0);
        wr(5'd1, 32'hFF);
        rd(5'd1, v); chk("R2 threshold low bits", v, 32'hF0);
        wr(5'd1, 32'h0B);
        rd(5'd1, v); chk("R2 threshold write of low bits only", v, 0);
        wr(5'd8, 0);

        // R3 pending latch
        m_en = 32'(1) << 5; wr(5'd2, m_en);
        irq_req[5] = 1'b1; tick();
        rd(5'd3, v); chk("R3 edge sets pending", v, 32'h20);
        exp_take("R3 edge offers line 5", 8'd21);
        wr(5'd4, 32'h20);
        rd(5'd4, v); chk("R3 held level does not re-pend", v, 0);
        irq_req[5] = 1'b0; tick();
        irq_req[5] = 1'b1;
        wr(5'd4, 32'h20);
        rd(5'd3, v); chk("R3 edge beats same-cycle clear", v, 32'h20);
        ack();
        rd(5'd3, v); chk("R3 acknowledge clears pending", v, 0);
        done();
        irq_req[5] = 1'b0;
        wr(5'd3, 32'h80);
        rd(5'd3, v); chk("R3 software set", v, 32'h80);
        exp_none("R4 disabled line not offered");
        wr(5'd4, 32'h80);
        rd(5'd3, v); chk("R3 software clear", v, 0);

        // R4 selection
        set_prio(3, 4'd4); set_prio(9, 4'd2); set_prio(12, 4'd2);
        m_en = (32'(1) << 3) | (32'(1) << 9) | (32'(1) << 12); wr(5'd2, m_en);
        wr(5'd3, m_en);
        exp_take("R4 tie goes to lowest line", 8'd25);
        m_en[9] = 1'b0; wr(5'd2, m_en);
        exp_take("R4 disabled line skipped", 8'd28);

        // R5 threshold
        wr(5'd1, 32'h20); exp_none("R5 threshold masks equal and lower");
        wr(5'd1, 32'h30); exp_take("R5 threshold passes higher", 8'd28);
        wr(5'd1, 32'h00); exp_take("R5 zero threshold masks nothing", 8'd28);

        // R6 and R8 global mask and non-maskable request
        wr(5'd0, 32'h1); exp_none("R6 global mask blocks lines");
        nmi_req = 1'b1; tick();
        exp_take("R6 non-maskable passes global mask", 8'd2);
        ack();
        exp_none("R8 non-maskable not re-offered");
        wr(5'd0, 32'h0); exp_none("R8 lines cannot preempt non-maskable");
        done();
        exp_take("R9 completion returns to thread", 8'd28);
        nmi_req = 1'b0;

        // R7 and R9 nesting
        ack();
        exp_none("R7 lower priority waits");
        m_en[9] = 1'b1; wr(5'd2, m_en);
        exp_none("R7 equal priority waits");
        set_prio(20, 4'd1);
        m_en[20] = 1'b1; wr(5'd2, m_en);
        wr(5'd3, 32'(1) << 20);
        exp_take("R7 higher priority preempts", 8'd36);
        ack();
        done();
        exp_none("R9 popped to preempted level");
        done();
        exp_take("R9 popped to thread", 8'd25);
        ack(); done();
        exp_take("R9 lower line after completion", 8'd19);
        ack(); done();
        exp_none("R9 all served");

        // R11 acknowledge and completion in the same cycle
        set_prio(6, 4'd6); set_prio(7, 4'd4); set_prio(8, 4'd1); set_prio(10, 4'd5);
        m_en = m_en | 32'h5C0; wr(5'd2, m_en);
        wr(5'd3, 32'(1) << 6); exp_take("R11 setup first", 8'd22); ack();
        wr(5'd3, 32'(1) << 7); exp_take("R11 setup second", 8'd23); ack();
        wr(5'd3, 32'(1) << 8); exp_take("R11 offered", 8'd24);
        core_ack = 1'b1; core_done = 1'b1; tick(); core_ack = 1'b0; core_done = 1'b0;
        wr(5'd3, 32'(1) << 10);
        exp_none("R11 new handler is running");
        done();
        exp_take("R11 level under new handler", 8'd26);
        ack(); done(); done();
        exp_none("R11 unwound");

        // R9 stack depth: sixteen configurable levels then non-maskable
        for (int k = 0; k < 16; k++) m_prio[k] = 4'(15 - k);
        for (int w = 0; w < 4; w++) wr_prio_word(w);
        m_en = 32'h0000_FFFF; wr(5'd2, m_en);
        for (int k = 0; k < 16; k++) begin
            wr(5'd3, 32'(1) << k);
            exp_take("R9 nest step", 8'(16 + k));
            ack();
        end
        nmi_req = 1'b1; tick();
        exp_take("R9 non-maskable on top of full nest", 8'd2);
        ack();
        nmi_req = 1'b0;
        for (int k = 0; k < 16; k++) done();
        wr(5'd3, 32'h1);
        exp_none("R9 lowest stacked level restored");
        done();
        exp_take("R9 thread after full unwind", 8'd16);
        ack(); done();

        // R10 wake
        wr(5'd0, 32'h1);
        wr(5'd3, 32'h1);
        core_sleep = 1'b1; #1;
        chk("R10 wake despite global mask", 32'(wake), 1);
        chk("R10 no take under global mask", 32'(take_valid), 0);
        wr(5'd1, 32'hF0);
        chk("R10 threshold suppresses wake", 32'(wake), 0);
        wr(5'd1, 32'h00);
        wr(5'd2, 32'h0);
        chk("R10 disabled line no wake", 32'(wake), 0);
        wr(5'd2, m_en);
        chk("R10 wake restored", 32'(wake), 1);
        core_sleep = 1'b0; #1;
        chk("R10 no wake when awake", 32'(wake), 0);
        wr(5'd0, 32'h0);
        exp_take("R6 mask released", 8'd16);
        wr(5'd4, 32'hFFFF_FFFF);

        // random phase, thread level only
        rst = 1'b1; tick(); tick(); rst = 1'b0; tick();
        for (int i = 0; i < NL; i++) m_prio[i] = '0;
        for (int it = 0; it < 150; it++) begin
            for (int i = 0; i < NL; i++) m_prio[i] = 4'($urandom);
            m_en    = $urandom | $urandom;
            m_pend  = $urandom & $urandom & $urandom;
            m_thr   = ($urandom % 3 == 0) ? 4'd0 : 4'($urandom);
            m_mask  = ($urandom % 4 == 0);
            m_sleep = 1'($urandom);
            core_sleep = m_sleep;
            for (int w = 0; w < 8; w++) wr_prio_word(w);
            wr(5'd2, m_en);
            wr(5'd4, 32'hFFFF_FFFF);
            wr(5'd3, m_pend);
            wr(5'd1, {24'd0, m_thr, 4'($urandom)});
            wr(5'd0, 32'(m_mask));
            model(ev, evec, ew);
            chk("R4 R5 R6 random take_valid", 32'(take_valid), 32'(ev));
            chk("R4 random take_vector", 32'(take_vector), 32'(evec));
            chk("R10 random wake", 32'(wake), 32'(ew));
        end
        core_sleep = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule